// File: doc/BRIEF.md
# TDM Transmit Framer

This block is the transmit framing engine of a time-division-multiplexed audio port. It runs on the bit clock. It produces a frame sync in one of several serial formats, counts bit positions inside each slot and slots inside each frame, and shifts sample words out MSB-first on up to six serial data lines. Any slot can be masked off, and each data line is undriven for a slot that is masked off or for a line that is not enabled.

Sample words arrive on a ready/valid input. Each enabled line has one holding register. An accepted word goes to the lowest-numbered enabled line whose holding register is empty. At the start of each active slot, every enabled line moves its held word into its shifter. The frame-sync shape comes from three static controls: length (one bit or one slot), timing (one bit early or aligned with the first data bit) and polarity. Together these cover I2S, left-justified and the two DSP formats.

To start, software enables the data lines, writes the upper half of the slot mask, and then writes the lower half. The write of the lower half starts the frame. Clearing every line enable stops output at the end of the current frame. The block also provides last-slot, even-slot and underrun flags.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, `busy` is 0, `sd_oe` and `sd` are all zero, `s_ready` is 0 while `line_en` is zero, and `fs` sits at its inactive level, which equals `fs_invert`.
- R2: A write to the upper mask half (`mask_hi_we`, bits 31..16) never starts the block. A write to the lower half (`mask_lo_we`, bits 15..0) while idle with `line_en` nonzero starts it. The cycle after that write is a single lead cycle with `busy`=1 and no data driven, and slot 0 bit 0 follows it. Mask bit i enables slot i, including slots 16 to 31.
- R3: A frame lasts (`slots_m1`+1)×(`slot_bits_m1`+1) bit clocks, and `busy` stays 1 from the lead cycle for as long as the block runs.
- R4: With `fs_slot_long`=0 the frame sync is active for one bit clock per frame. With `fs_slot_long`=1 it is active for one whole slot.
- R5: With `fs_early`=0 the active sync covers slot 0 starting at its bit 0. With `fs_early`=1 the whole window moves one bit clock earlier, so a one-bit sync sits on the last bit of the previous frame (or in the lead cycle). `fs` equals the active state XOR `fs_invert`.
- R6: Each slot carries the low `sample_bits_m1`+1 bits of its word MSB-first. With `right_just`=0 the sample fills the first bits of the slot. With `right_just`=1 it fills the last bits. All other bits of the slot are 0.
- R7: In network mode (`network`=1), a slot whose mask bit is 0 has `sd_oe`=0 and `sd`=0 on every line, and it consumes no word.
- R8: In normal mode (`network`=0), only slot 0 of each frame is driven and the mask is ignored. This gives one word per line per frame.
- R9: Only lines with a `line_en` bit set are driven. Within an active slot, enabled lines take consecutive words in ascending line order, and slots take them in time order.
- R10: `last_slot` is 1 for every bit of slot `slots_m1`. `even_slot` is 1 for every bit of a slot with an even index. Both flags are 0 when idle and in the lead cycle.
- R11: If an enabled line has no held word when an active slot starts, that line still drives the slot but sends zeros, and `underrun` pulses high during bit 0 of that slot.
- R12: When `line_en` is cleared during a frame, that frame completes with its latched lines. `busy` then drops, and output goes idle right after the frame's last bit. No early sync is issued for a following frame.
- R13: `s_ready` is 1 exactly when some enabled line has an empty holding register. When all enabled holding registers are full, `s_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| line_en | input | LINES | Data line enables |
| slots_m1 | input | log2(MAX_SLOTS) | Slots per frame minus one |
| slot_bits_m1 | input | log2(SLOT_MAX) | Bits per slot minus one |
| sample_bits_m1 | input | log2(SLOT_MAX) | Sample width minus one (not above slot width) |
| fs_slot_long | input | 1 | Sync length: 0 one bit, 1 one slot |
| fs_early | input | 1 | Sync leads the data by one bit |
| fs_invert | input | 1 | Sync polarity inversion |
| right_just | input | 1 | Sample placed at the end of the slot |
| network | input | 1 | 1 masked multi-slot mode, 0 slot 0 only |
| mask_hi_we | input | 1 | Write the upper slot mask half |
| mask_lo_we | input | 1 | Write the lower slot mask half and start |
| mask_wdata | input | MAX_SLOTS/2 | Mask half data |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | Sample word accepted |
| s_data | input | SAMPLE_W | Sample word |
| fs | output | 1 | Frame sync |
| sd | output | LINES | Serial data |
| sd_oe | output | LINES | Per-line drive enable |
| busy | output | 1 | Framer running |
| last_slot | output | 1 | Final slot of frame in progress |
| even_slot | output | 1 | Even-indexed slot in progress |
| underrun | output | 1 | Slot started without data |

## Verification
The embedded properties check, on every cycle, that no line is driven while idle, that a one-bit sync never lasts two cycles, that the last slot always wraps to slot 0 bit 0, that a stop only happens on the last bit of a frame, that a start always enters the lead cycle, and that an underrun only occurs on a driven slot. Only the bench's sweeps can show the bit-exact sync shape of each format, the placement and zero padding of samples, which word lands on which line and slot, and the behaviour of mask, normal mode and stop across whole frames.

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int LINES     = 6,
  parameter int MAX_SLOTS = 32,
  parameter int SLOT_MAX  = 32,
  parameter int SAMPLE_W  = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LINES-1:0]              line_en,
  input  logic [$clog2(MAX_SLOTS)-1:0]  slots_m1,
  input  logic [$clog2(SLOT_MAX)-1:0]   slot_bits_m1,
  input  logic [$clog2(SLOT_MAX)-1:0]   sample_bits_m1,
  input  logic                          fs_slot_long,
  input  logic                          fs_early,
  input  logic                          fs_invert,
  input  logic                          right_just,
  input  logic                          network,
  input  logic                          mask_hi_we,
  input  logic                          mask_lo_we,
  input  logic [MAX_SLOTS/2-1:0]        mask_wdata,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [SAMPLE_W-1:0]           s_data,
  output logic                          fs,
  output logic [LINES-1:0]              sd,
  output logic [LINES-1:0]              sd_oe,
  output logic                          busy,
  output logic                          last_slot,
  output logic                          even_slot,
  output logic                          underrun
);
  localparam int SCW  = $clog2(MAX_SLOTS);
  localparam int BCW  = $clog2(SLOT_MAX);
  localparam int HALF = MAX_SLOTS / 2;

  logic                 running, pre;
  logic [SCW-1:0]       slot_q;
  logic [BCW-1:0]       bit_q;
  logic [MAX_SLOTS-1:0] mask_q;
  logic [LINES-1:0]     lines_q, full_q, oe_q;
  logic [SAMPLE_W-1:0]  hold_q [LINES];
  logic [SLOT_MAX-1:0]  sr_q   [LINES];
  logic                 urun_q;

  logic slot_end, frame_end, stopping, start, slot_on, load, accept;
  logic [SCW-1:0]      next_slot;
  logic [LINES-1:0]    lines_nx, free, pick, take;
  logic [BCW:0]        slot_n, smp_n;
  logic [SLOT_MAX-1:0] smp_mask;

  assign slot_end  = running && (bit_q == slot_bits_m1);
  assign frame_end = slot_end && (slot_q == slots_m1);
  assign stopping  = frame_end && (line_en == '0);
  assign start     = !running && mask_lo_we && (|line_en);
  assign next_slot = (slot_q == slots_m1) ? '0 : slot_q + 1'b1;
  assign slot_on   = network ? mask_q[next_slot] : (next_slot == '0);
  assign lines_nx  = frame_end ? line_en : lines_q;
  assign load      = slot_end && !stopping;
  assign take      = load && slot_on ? (lines_nx & full_q) : '0;

  assign free    = line_en & ~full_q;
  assign pick    = free & (~free + LINES'(1));
  assign s_ready = |free;
  assign accept  = s_valid && s_ready;

  assign slot_n   = {1'b0, slot_bits_m1} + 1'b1;
  assign smp_n    = {1'b0, sample_bits_m1} + 1'b1;
  assign smp_mask = ~({SLOT_MAX{1'b1}} << smp_n);

  function automatic logic [SLOT_MAX-1:0] place(input logic [SAMPLE_W-1:0] w);
    logic [SLOT_MAX-1:0] v;
    v = SLOT_MAX'(w) & smp_mask;
    return right_just ? v << (SLOT_MAX - int'(slot_n)) : v << (SLOT_MAX - int'(smp_n));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre     <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
      lines_q <= '0;
    end else if (start) begin
      running <= 1'b1;
      pre     <= 1'b1;
      slot_q  <= slots_m1;
      bit_q   <= slot_bits_m1;
      lines_q <= line_en;
    end else if (running) begin
      if (slot_end) begin
        bit_q  <= '0;
        slot_q <= next_slot;
        if (frame_end) begin
          pre     <= 1'b0;
          lines_q <= line_en;
          if (line_en == '0) running <= 1'b0;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      if (mask_hi_we) mask_q[MAX_SLOTS-1:HALF] <= mask_wdata;
      if (mask_lo_we) mask_q[HALF-1:0]         <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      oe_q   <= '0;
      urun_q <= 1'b0;
      for (int l = 0; l < LINES; l++) begin
        hold_q[l] <= '0;
        sr_q[l]   <= '0;
      end
    end else begin
      full_q <= (full_q & ~take) | (accept ? pick : '0);
      urun_q <= load && slot_on && (|(lines_nx & ~full_q));
      for (int l = 0; l < LINES; l++) begin
        if (accept && pick[l]) hold_q[l] <= s_data;
        if (load) begin
          oe_q[l] <= lines_nx[l] && slot_on;
          sr_q[l] <= take[l] ? place(hold_q[l]) : '0;
        end else begin
          if (stopping) oe_q[l] <= 1'b0;
          sr_q[l] <= {sr_q[l][SLOT_MAX-2:0], 1'b0};
        end
      end
    end
  end

  logic aligned_act, early_act, fs_act;
  assign aligned_act = running && !pre && (slot_q == '0) && (fs_slot_long || bit_q == '0);
  assign early_act   = running && ((frame_end && (|line_en)) ||
                       (!pre && fs_slot_long && slot_q == '0 && bit_q != slot_bits_m1));
  assign fs_act      = fs_early ? early_act : aligned_act;
  assign fs          = fs_act ^ fs_invert;

  always_comb begin
    for (int l = 0; l < LINES; l++) sd[l] = sr_q[l][SLOT_MAX-1] & oe_q[l];
  end
  assign sd_oe     = oe_q;
  assign busy      = running;
  assign last_slot = running && !pre && (slot_q == slots_m1);
  assign even_slot = running && !pre && !slot_q[0];
  assign underrun  = urun_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> oe_q == '0);

  p_start_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> pre && $past(mask_lo_we));

  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot && slot_end && (|line_en) |=> running && slot_q == '0 && bit_q == '0);

  p_sync_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fs_act && !fs_slot_long && !(slots_m1 == '0 && slot_bits_m1 == '0) |=> !fs_act);

  p_underrun_driven_r11: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q |-> |oe_q);

  p_stop_on_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(slot_q == slots_m1 && bit_q == slot_bits_m1));

  p_accept_fills_r13: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> |full_q);
endmodule

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  localparam int CLK_P = 10;
  localparam int L = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0] line_en = '0;
  logic [4:0] slots_m1 = '0, slot_bits_m1 = '0, sample_bits_m1 = '0;
  logic fs_slot_long = 0, fs_early = 0, fs_invert = 0, right_just = 0, network = 0;
  logic mask_hi_we = 0, mask_lo_we = 0;
  logic [15:0] mask_wdata = '0;
  logic s_valid = 0, s_ready;
  logic [23:0] s_data = '0;
  logic fs, busy, last_slot, even_slot, underrun;
  logic [L-1:0] sd, sd_oe;

  int total = 0, bad = 0, widx = 0;
  bit hs_prev = 0, feed_on = 0;

  tdm_slot_tx i_tdm_slot_tx (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .slots_m1(slots_m1),
    .slot_bits_m1(slot_bits_m1), .sample_bits_m1(sample_bits_m1),
    .fs_slot_long(fs_slot_long), .fs_early(fs_early), .fs_invert(fs_invert),
    .right_just(right_just), .network(network), .mask_hi_we(mask_hi_we),
    .mask_lo_we(mask_lo_we), .mask_wdata(mask_wdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .fs(fs), .sd(sd), .sd_oe(sd_oe),
    .busy(busy), .last_slot(last_slot), .even_slot(even_slot), .underrun(underrun));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 190000);
    bad++; total++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [23:0] pat(int k);
    return 24'((k * 40503 + 1237) ^ (k << 9));
  endfunction

  function automatic bit exp_bit(logic [23:0] w, int W, int N, bit rj, int b);
    int off = rj ? W - N : 0;
    if (b < off || b >= off + N) return 1'b0;
    return w[N - 1 - (b - off)];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (hs_prev) widx++;
    s_valid = feed_on;
    s_data  = pat(widx);
    hs_prev = s_valid && s_ready;
  endtask

  task automatic run_case(int S, int W, int N, bit slong, bit early, bit inv, bit rj,
                          bit net, logic [31:0] mask, logic [L-1:0] lines, bit feed,
                          int frames, int sf, string rq);
    int F = S * W;
    int nfr = (sf >= 0) ? sf + 1 : frames + 1;
    int last_p = (sf >= 0) ? nfr * F + 2 : frames * F - 1;
    int lc = $countones(lines);
    int act_pf = 0;
    @(negedge clk);
    rst_n = 0; line_en = '0; feed_on = 0; s_valid = 0;
    slots_m1 = 5'(S - 1); slot_bits_m1 = 5'(W - 1); sample_bits_m1 = 5'(N - 1);
    fs_slot_long = slong; fs_early = early; fs_invert = inv; right_just = rj; network = net;
    @(negedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "sd_oe", 32'(sd_oe), 0);
    check("R1", "fs", 32'(fs), 32'(inv));
    check("R1", "s_ready", 32'(s_ready), 0);
    widx = 0; hs_prev = 0;
    line_en = lines; feed_on = feed;
    tick(); mask_hi_we = 1; mask_wdata = mask[31:16];
    tick(); mask_hi_we = 0;
    for (int i = 0; i < 6; i++) tick();
    check("R2", "busy after upper write", 32'(busy), 0);
    if (feed) check("R13", "s_ready when held words full", 32'(s_ready), 0);
    if (feed) check("R13", "prefill count", 32'(widx), 32'(lc));
    for (int s = 0; s < S; s++) if (!net ? s == 0 : mask[s]) act_pf++;
    tick(); mask_lo_we = 1; mask_wdata = mask[15:0];
    for (int n = 0; n <= last_p + 1; n++) begin
      int p = n - 1;
      bit run = p < nfr * F;
      logic [L-1:0] e_oe = '0, e_sd = '0;
      bit e_fs = 0, e_last = 0, e_even = 0, e_ur = 0;
      tick(); mask_lo_we = 0;
      if (n == 0) check("R2", "lead cycle busy", 32'(busy), 1);
      if (run && p >= 0) begin
        int slot = (p / W) % S, b = p % W, fr = p / F;
        bit act = net ? mask[slot] : (slot == 0);
        int k = fr * act_pf;
        int rank = 0;
        for (int s = 0; s < slot; s++) if (!net ? s == 0 : mask[s]) k++;
        for (int l = 0; l < L; l++) if (lines[l]) begin
          if (act) begin
            e_oe[l] = 1;
            e_sd[l] = feed ? exp_bit(pat(k * lc + rank), W, N, rj, b) : 1'b0;
          end
          rank++;
        end
        e_last = (slot == S - 1);
        e_even = (slot % 2 == 0);
        e_ur = !feed && act && b == 0 && lc > 0;
      end
      if (run) begin
        int q = early ? p + 1 : p;
        e_fs = (q >= 0) && (q < nfr * F) && ((q % F) / W == 0) && (slong || q % W == 0);
      end
      check("R3", "busy", 32'(busy), 32'(run));
      check("R5", "fs", 32'(fs), 32'(e_fs ^ inv));
      check(rq, "sd_oe", 32'(sd_oe), 32'(e_oe));
      check((rq == "R7" || rq == "R8") ? rq : "R6", "sd", 32'(sd), 32'(e_sd));
      check("R10", "last_slot", 32'(last_slot), 32'(e_last));
      check("R10", "even_slot", 32'(even_slot), 32'(e_even));
      check("R11", "underrun", 32'(underrun), 32'(e_ur));
      if (sf >= 0 && p == sf * F + F / 2) line_en = '0;
    end
  endtask

  initial begin
    // R4 R5: formats x polarity x slot count
    for (int f = 0; f < 4; f++)
      for (int iv = 0; iv < 2; iv++)
        for (int s = 1; s <= 4; s++) begin
          bit sl = (f < 2);
          bit ea = (f == 0 || f == 2);
          bit ib = (f == 0);
          run_case(s, 8, 6, sl, ea, ib ^ iv[0], 0, 1, 32'hFFFF_FFFF, 6'b000001, 1, 2, -1, "R6");
        end
    // R6: slot width vs sample width, both justifications
    for (int wi = 0; wi < 4; wi++)
      for (int ni = 0; ni < 2; ni++)
        for (int r = 0; r < 2; r++) begin
          int W = (wi == 0) ? 3 : (wi == 1) ? 8 : (wi == 2) ? 16 : 32;
          int N = (ni == 0) ? ((W < 24) ? W : 24) : W / 2;
          run_case(2, W, N, 0, 1, 0, r[0], 1, 32'h3, 6'b000010, 1, 2, -1, "R6");
        end
    // R7: slot masks
    run_case(4, 4, 4, 0, 0, 0, 0, 1, 32'hA, 6'b000001, 1, 3, -1, "R7");
    run_case(4, 4, 3, 1, 0, 0, 1, 1, 32'h1, 6'b000001, 1, 3, -1, "R7");
    run_case(4, 4, 4, 0, 1, 1, 0, 1, 32'h6, 6'b000001, 1, 3, -1, "R7");
    run_case(4, 4, 4, 0, 0, 0, 0, 1, 32'h0, 6'b000001, 1, 2, -1, "R7");
    // R8: normal mode ignores mask
    run_case(3, 4, 4, 0, 0, 0, 0, 0, 32'h6, 6'b000001, 1, 3, -1, "R8");
    // R2: upper mask half reaches slots 16..19
    run_case(20, 3, 3, 0, 1, 0, 0, 1, 32'h000A_8001, 6'b000001, 1, 2, -1, "R2");
    // R9: several lines
    run_case(2, 8, 8, 0, 0, 0, 0, 1, 32'h3, 6'b000101, 1, 3, -1, "R9");
    run_case(2, 10, 8, 1, 1, 1, 1, 1, 32'h3, 6'b111111, 1, 2, -1, "R9");
    // R11: no data at all
    run_case(2, 6, 4, 0, 0, 0, 0, 1, 32'h3, 6'b000001, 0, 2, -1, "R11");
    // R12: stop during frame 1
    run_case(2, 6, 6, 0, 1, 0, 0, 1, 32'h3, 6'b000011, 1, 0, 1, "R12");
    run_case(3, 4, 4, 1, 0, 1, 0, 1, 32'h5, 6'b000001, 1, 0, 0, "R12");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule